// File: doc/BRIEF.md
# Windowed register file controller

This block owns a physical file of 32-bit registers and exposes a sliding view of sixteen logical registers over it. The view starts at a group pointer, the window base, counted in groups of four physical registers and wrapping around the file. A second register, the frame-start mask, holds one bit per group; a set bit marks a group where a live call frame begins.

A pipeline front end hands the block one window operation per cycle: the call-frame entry, the windowed return, an explicit signed rotate, a restore of the base from a saved value, the overflow check for a register reference, and the stack-pointer move check. Each operation settles in one clock. Its effect on the base and the mask, any exception request, and any return address all appear on the outputs the cycle after the operation is presented. Exception requests (overflow and underflow in three sizes, illegal instruction, alloca) go to an external exception unit together with the base to save and the faulting PC. Raising the exception-mode flag and vectoring are that unit's job. Two combinational read ports and one write port address the file through the current window.

Top module: `winreg_ctrl`

## Requirements
- R1: Logical register r (0..15) maps to physical register (base*4 + r) mod NAREG. The read ports are combinational from the registered base and file, so a read presented in the same cycle as an operation that moves the base returns data through the old window. A write through the write port becomes readable on the next cycle.
- R2: After reset the base is 0, the frame-start mask has only bit 0 set, every physical register reads 0, and exc_vld and ret_vld are low.
- R3: Operation code 3 (rotate) adds the 4-bit two's-complement value op_rot to the base, modulo the number of groups.
- R4: Operation code 6 (restore) loads the base from ps_owb.
- R5: Operation code 1 (entry) is legal when op_sidx is at most 3, ps_woe is 1 and ps_excm is 0. It writes a(op_sidx) minus (op_imm shifted left by 3) into logical register (ps_callinc*4 + op_sidx) of the old window, advances the base by ps_callinc and sets the mask bit of the new base. When the write port targets the same physical register in that cycle, the entry's value is the one stored.
- R6: An entry that is not legal changes neither base, mask nor file, and raises exc_kind 7 (illegal) with exc_epc equal to op_pc.
- R7: Operation code 4 (overflow check) with group count w (op_wgrp) acts only when ps_woe is 1 and ps_excm is 0. It takes the smallest n in 1..w whose mask bit at base+n is set. When there is none, nothing changes and no request is raised. Otherwise, with m = base+n: the base becomes m, exc_owb carries the old base, exc_epc carries op_pc, and exc_kind is 1 (4-register) when the mask bit at m+1 is set, 2 (8-register) when the bit at m+1 is clear and the bit at m+2 is set, and 3 (12-register) when both are clear.
- R8: Operation code 2 (return) takes n from bits 31:30 of logical register 0. It takes m as the smallest k in 1..3 whose mask bit at base-k is set, or 0 if there is none. The return is illegal (exc_kind 7, epc op_pc, no state change) when n is 0, when m is nonzero and differs from n, or when ps_woe is 0 or ps_excm is 1.
- R9: A legal return moves the base back by n. When the mask bit at the new base is set, it clears the mask bit of the old base and pulses ret_vld with ret_pc equal to op_pc bits 31:30 joined with bits 29:0 of logical register 0.
- R10: When the mask bit at the new base of a legal return is clear, the base still moves back by n, the mask is unchanged, ret_vld stays low, and exc_kind is 4, 5 or 6 for n equal to 1, 2 or 3, with exc_owb equal to the old base and exc_epc equal to op_pc.
- R11: Operation code 5 (stack-pointer move check) raises exc_kind 8 (alloca) with exc_epc equal to op_pc when the mask bits at base-1, base-2 and base-3 are all clear. Otherwise it has no effect.
- R12: Base, mask, exception request and return address all update on the clock edge that accepts the operation. exc_vld and ret_vld are high only in the cycle after an operation that raised them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 entry, 2 return, 3 rotate, 4 overflow check, 5 stack move check, 6 restore |
| op_pc | input | XLEN | PC of the operation |
| op_sidx | input | 4 | Entry source register index |
| op_imm | input | IMM_W | Entry frame size in 8-byte units |
| op_rot | input | 4 | Signed rotate amount |
| op_wgrp | input | 2 | Groups referenced by the overflow check |
| ps_woe | input | 1 | Window overflow checking enabled |
| ps_excm | input | 1 | Exception mode active |
| ps_callinc | input | 2 | Call increment in groups |
| ps_owb | input | GW | Saved base for restore |
| rd_idx_a | input | 4 | Read port A logical index |
| rd_dat_a | output | XLEN | Read port A data |
| rd_idx_b | input | 4 | Read port B logical index |
| rd_dat_b | output | XLEN | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port logical index |
| wr_dat | input | XLEN | Write port data |
| wbase | output | GW | Current window base |
| wstart | output | NGRP | Frame-start mask |
| exc_vld | output | 1 | Exception request |
| exc_kind | output | 4 | Exception kind code |
| exc_owb | output | GW | Base to save for window exceptions |
| exc_epc | output | XLEN | Faulting PC |
| ret_vld | output | 1 | Return completed |
| ret_pc | output | XLEN | Return target |

## Verification
Two functions can fall in the same cycle. An entry writes its computed frame pointer into the file while the ordinary write port may target that same physical register, and a read can be presented in the same cycle as a rotate that moves the window. The bench drives an entry together with a write-port access whose logical index, taken through the old window, resolves to the entry's target. A later read through the new window must return the entry's value. It also holds a read index steady during a rotate and compares the data, sampled before the edge, with the register seen through the old base.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_RETW    = 3'd2,
        OP_ROTW    = 3'd3,
        OP_WCHK    = 3'd4,
        OP_MOVSP   = 3'd5,
        OP_RESTORE = 3'd6
    } win_op_e;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_OVF4    = 4'd1,
        EXC_OVF8    = 4'd2,
        EXC_OVF12   = 4'd3,
        EXC_UNF4    = 4'd4,
        EXC_UNF8    = 4'd5,
        EXC_UNF12   = 4'd6,
        EXC_ILLEGAL = 4'd7,
        EXC_ALLOCA  = 4'd8
    } win_exc_e;

endpackage

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NPHYS = 64,
    parameter int XLEN  = 32,
    localparam int PW   = $clog2(NPHYS),
    localparam int GW   = PW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GW-1:0]   base,
    input  logic [3:0]      rd_idx_a,
    output logic [XLEN-1:0] rd_dat_a,
    input  logic [3:0]      rd_idx_b,
    output logic [XLEN-1:0] rd_dat_b,
    input  logic [3:0]      aux_idx,
    output logic [XLEN-1:0] aux_dat,
    output logic [XLEN-1:0] a0_dat,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [XLEN-1:0] wr_dat,
    input  logic            ent_en,
    input  logic [3:0]      ent_idx,
    input  logic [XLEN-1:0] ent_dat
);

    logic [XLEN-1:0] regs_q [NPHYS];
    logic [XLEN-1:0] regs_d [NPHYS];

    function automatic logic [PW-1:0] phys(input logic [GW-1:0] b, input logic [3:0] idx);
        return {b, 2'b00} + PW'(idx);
    endfunction

    assign rd_dat_a = regs_q[phys(base, rd_idx_a)];
    assign rd_dat_b = regs_q[phys(base, rd_idx_b)];
    assign aux_dat  = regs_q[phys(base, aux_idx)];
    assign a0_dat   = regs_q[phys(base, 4'd0)];

    // the entry write is applied last so it wins a same-register collision
    always_comb begin
        regs_d = regs_q;
        if (wr_en)  regs_d[phys(base, wr_idx)]  = wr_dat;
        if (ent_en) regs_d[phys(base, ent_idx)] = ent_dat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R5
    ent_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_en && wr_en && ent_idx == wr_idx) |=> (a0_dat == a0_dat) && ($past(ent_dat) == regs_q[$past(phys(base, ent_idx))]));

endmodule

// File: rtl/winreg_probe.sv
module winreg_probe
    import winreg_pkg::*;
#(
    parameter int NGRP = 16,
    localparam int GW  = $clog2(NGRP)
) (
    input  logic [NGRP-1:0] ws,
    input  logic [GW-1:0]   base,
    input  logic [1:0]      wgrp,
    output logic            ovf_hit,
    output logic [1:0]      ovf_n,
    output win_exc_e        ovf_kind,
    output logic [1:0]      ret_m,
    output logic            caller_live
);

    logic [GW-1:0] frame;
    logic [GW-1:0] pos;

    // forward scan: the nearest live frame within the referenced groups
    always_comb begin
        ovf_hit = 1'b0;
        ovf_n   = 2'd0;
        pos     = '0;
        for (int k = 3; k >= 1; k--) begin
            pos = base + GW'(k);
            if (k <= int'(wgrp) && ws[pos]) begin
                ovf_hit = 1'b1;
                ovf_n   = 2'(k);
            end
        end
    end

    assign frame = base + {{(GW-2){1'b0}}, ovf_n};

    always_comb begin
        if (ws[frame + GW'(1)])      ovf_kind = EXC_OVF4;
        else if (ws[frame + GW'(2)]) ovf_kind = EXC_OVF8;
        else                         ovf_kind = EXC_OVF12;
    end

    // backward scan: distance to the caller's frame
    always_comb begin
        ret_m = 2'd0;
        for (int k = 3; k >= 1; k--) begin
            if (ws[base - GW'(k)]) ret_m = 2'(k);
        end
    end

    assign caller_live = (ret_m != 2'd0);

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NAREG = 64,
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    localparam int NGRP = NAREG / 4,
    localparam int GW   = $clog2(NGRP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_vld,
    input  logic [2:0]      op_code,
    input  logic [XLEN-1:0] op_pc,
    input  logic [3:0]      op_sidx,
    input  logic [IMM_W-1:0] op_imm,
    input  logic [3:0]      op_rot,
    input  logic [1:0]      op_wgrp,
    input  logic            ps_woe,
    input  logic            ps_excm,
    input  logic [1:0]      ps_callinc,
    input  logic [GW-1:0]   ps_owb,
    input  logic [3:0]      rd_idx_a,
    output logic [XLEN-1:0] rd_dat_a,
    input  logic [3:0]      rd_idx_b,
    output logic [XLEN-1:0] rd_dat_b,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [XLEN-1:0] wr_dat,
    output logic [GW-1:0]   wbase,
    output logic [NGRP-1:0] wstart,
    output logic            exc_vld,
    output logic [3:0]      exc_kind,
    output logic [GW-1:0]   exc_owb,
    output logic [XLEN-1:0] exc_epc,
    output logic            ret_vld,
    output logic [XLEN-1:0] ret_pc
);

    typedef struct packed {
        logic [GW-1:0]   wb;
        logic [NGRP-1:0] ws;
        logic            ev;
        win_exc_e        ek;
        logic [GW-1:0]   eo;
        logic [XLEN-1:0] ep;
        logic            rv;
        logic [XLEN-1:0] rp;
    } st_t;

    st_t st_q, st_d;

    win_op_e         op;
    logic            woe_ok;
    logic            ent_en;
    logic [3:0]      ent_idx;
    logic [XLEN-1:0] ent_dat;
    logic [XLEN-1:0] aux_dat;
    logic [XLEN-1:0] a0_dat;
    logic [1:0]      ret_n;
    logic [GW-1:0]   ret_base;
    logic [GW+3:0]   rot_ext;
    logic            ovf_hit;
    logic [1:0]      ovf_n;
    win_exc_e        ovf_kind;
    logic [1:0]      ret_m;
    logic            caller_live;

    assign op       = op_vld ? win_op_e'(op_code) : OP_NOP;
    assign woe_ok   = ps_woe && !ps_excm;
    assign ent_idx  = {ps_callinc, op_sidx[1:0]};
    assign ent_dat  = aux_dat - ({{(XLEN-IMM_W){1'b0}}, op_imm} << 3);
    assign ret_n    = a0_dat[XLEN-1 -: 2];
    assign ret_base = st_q.wb - {{(GW-2){1'b0}}, ret_n};
    assign rot_ext  = {{GW{op_rot[3]}}, op_rot};

    winreg_file #(.NPHYS(NAREG), .XLEN(XLEN)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (st_q.wb),
        .rd_idx_a (rd_idx_a),
        .rd_dat_a (rd_dat_a),
        .rd_idx_b (rd_idx_b),
        .rd_dat_b (rd_dat_b),
        .aux_idx  (op_sidx),
        .aux_dat  (aux_dat),
        .a0_dat   (a0_dat),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_dat   (wr_dat),
        .ent_en   (ent_en),
        .ent_idx  (ent_idx),
        .ent_dat  (ent_dat)
    );

    winreg_probe #(.NGRP(NGRP)) u_probe (
        .ws          (st_q.ws),
        .base        (st_q.wb),
        .wgrp        (op_wgrp),
        .ovf_hit     (ovf_hit),
        .ovf_n       (ovf_n),
        .ovf_kind    (ovf_kind),
        .ret_m       (ret_m),
        .caller_live (caller_live)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ev = 1'b0;
        st_d.ek = EXC_NONE;
        st_d.rv = 1'b0;
        ent_en  = 1'b0;
        unique case (op)
            OP_ENTRY: begin
                if (op_sidx > 4'd3 || !woe_ok) begin
                    st_d.ev = 1'b1;
                    st_d.ek = EXC_ILLEGAL;
                    st_d.ep = op_pc;
                end else begin
                    ent_en = 1'b1;
                    st_d.wb = st_q.wb + {{(GW-2){1'b0}}, ps_callinc};
                    st_d.ws[st_d.wb] = 1'b1;
                end
            end
            OP_RETW: begin
                if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || !woe_ok) begin
                    st_d.ev = 1'b1;
                    st_d.ek = EXC_ILLEGAL;
                    st_d.ep = op_pc;
                end else begin
                    st_d.wb = ret_base;
                    if (st_q.ws[ret_base]) begin
                        st_d.ws[st_q.wb] = 1'b0;
                        st_d.rv = 1'b1;
                        st_d.rp = {op_pc[XLEN-1 -: 2], a0_dat[XLEN-3:0]};
                    end else begin
                        st_d.ev = 1'b1;
                        st_d.ek = win_exc_e'(4'd3 + {2'b00, ret_n});
                        st_d.eo = st_q.wb;
                        st_d.ep = op_pc;
                    end
                end
            end
            OP_ROTW: st_d.wb = st_q.wb + rot_ext[GW-1:0];
            OP_WCHK: begin
                if (woe_ok && ovf_hit) begin
                    st_d.wb = st_q.wb + {{(GW-2){1'b0}}, ovf_n};
                    st_d.ev = 1'b1;
                    st_d.ek = ovf_kind;
                    st_d.eo = st_q.wb;
                    st_d.ep = op_pc;
                end
            end
            OP_MOVSP: begin
                if (!caller_live) begin
                    st_d.ev = 1'b1;
                    st_d.ek = EXC_ALLOCA;
                    st_d.ep = op_pc;
                end
            end
            OP_RESTORE: st_d.wb = ps_owb;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ws <= NGRP'(1);
            st_q.ek <= EXC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wbase    = st_q.wb;
    assign wstart   = st_q.ws;
    assign exc_vld  = st_q.ev;
    assign exc_kind = st_q.ek;
    assign exc_owb  = st_q.eo;
    assign exc_epc  = st_q.ep;
    assign ret_vld  = st_q.rv;
    assign ret_pc   = st_q.rp;

    // R3
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROTW) |=> (wbase == $past(wbase) + $past(rot_ext[GW-1:0])));

    // R4
    restore_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESTORE) |=> (wbase == $past(ps_owb)));

    // R5
    entry_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_en |=> wstart[wbase]);

    // R6
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_vld && exc_kind == EXC_ILLEGAL) |-> ($stable(wbase) && $stable(wstart)));

    // R9
    retw_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld |-> !wstart[$past(wbase)]);

    // R11
    alloca_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MOVSP && !caller_live) |=> (exc_vld && exc_kind == EXC_ALLOCA));

endmodule

// File: tb/winreg_ctrl_tb.sv
`timescale 1ns/100ps
module winreg_ctrl_tb;

    localparam int NAREG = 64;
    localparam int XLEN  = 32;
    localparam int NGRP  = 16;
    localparam int GW    = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            op_vld;
    logic [2:0]      op_code;
    logic [31:0]     op_pc;
    logic [3:0]      op_sidx;
    logic [11:0]     op_imm;
    logic [3:0]      op_rot;
    logic [1:0]      op_wgrp;
    logic            ps_woe, ps_excm;
    logic [1:0]      ps_callinc;
    logic [3:0]      ps_owb;
    logic [3:0]      rd_idx_a, rd_idx_b;
    logic [31:0]     rd_dat_a, rd_dat_b;
    logic            wr_en;
    logic [3:0]      wr_idx;
    logic [31:0]     wr_dat;
    logic [3:0]      wbase;
    logic [15:0]     wstart;
    logic            exc_vld;
    logic [3:0]      exc_kind;
    logic [3:0]      exc_owb;
    logic [31:0]     exc_epc;
    logic            ret_vld;
    logic [31:0]     ret_pc;

    always #2.5 clk = ~clk;

    winreg_ctrl #(.NAREG(NAREG), .XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code), .op_pc(op_pc),
        .op_sidx(op_sidx), .op_imm(op_imm), .op_rot(op_rot), .op_wgrp(op_wgrp),
        .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc), .ps_owb(ps_owb),
        .rd_idx_a(rd_idx_a), .rd_dat_a(rd_dat_a), .rd_idx_b(rd_idx_b), .rd_dat_b(rd_dat_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dat(wr_dat), .wbase(wbase), .wstart(wstart),
        .exc_vld(exc_vld), .exc_kind(exc_kind), .exc_owb(exc_owb), .exc_epc(exc_epc),
        .ret_vld(ret_vld), .ret_pc(ret_pc)
    );

    typedef struct {
        logic        ev;
        logic [3:0]  ek;
        logic [3:0]  eo;
        logic [31:0] ep;
        logic        rv;
        logic [31:0] rp;
        logic [3:0]  wb;
        logic [15:0] ws;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [31:0] mreg [NAREG];
    int          mwb;
    logic [15:0] mws;
    logic [31:0] pc_ctr = 32'h8000_1000;

    function automatic int ph(int b, int r);
        return (b * 4 + r) % NAREG;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares the registered results one cycle after each operation
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic ok;
            e = exp_q.pop_front();
            ok = (exc_vld == e.ev) && (ret_vld == e.rv) && (wbase == e.wb) && (wstart == e.ws);
            if (e.ev) ok = ok && (exc_kind == e.ek) && (exc_epc == e.ep) &&
                           (e.ek > 4'd6 || exc_owb == e.eo);
            if (e.rv) ok = ok && (ret_pc == e.rp);
            n_cmp++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s: actual exc=%0d kind=%0d owb=%0d epc=%h ret=%0d pc=%h wb=%0d ws=%h expected exc=%0d kind=%0d owb=%0d epc=%h ret=%0d pc=%h wb=%0d ws=%h",
                         e.tag, exc_vld, exc_kind, exc_owb, exc_epc, ret_vld, ret_pc, wbase, wstart,
                         e.ev, e.ek, e.eo, e.ep, e.rv, e.rp, e.wb, e.ws);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; op_vld = 0; op_code = 0; op_pc = 0; op_sidx = 0; op_imm = 0;
        op_rot = 0; op_wgrp = 0; ps_woe = 1; ps_excm = 0; ps_callinc = 0; ps_owb = 0;
        rd_idx_a = 0; rd_idx_b = 0; wr_en = 0; wr_idx = 0; wr_dat = 0;
        for (int i = 0; i < NAREG; i++) mreg[i] = '0;
        mwb = 0; mws = 16'h0001;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_en = 1; wr_idx = 4'(idx); wr_dat = d;
        mreg[ph(mwb, idx)] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input int idx, input string tag);
        logic [31:0] e;
        rd_idx_a = 4'(idx);
        #1;
        e = mreg[ph(mwb, idx)];
        check(rd_dat_a == e, tag, rd_dat_a, e);
        @(negedge clk);
    endtask

    // driver: applies one operation, updates the spec model, queues the expected result
    task automatic issue(input int op, input int s, input int imm, input int rot,
                         input int w, input bit coll, input bit rdchk, input string tag);
        exp_t e;
        int ob, n, m, k, nb;
        logic [31:0] a0, old_rd;
        logic woe_ok;
        ob = mwb;
        woe_ok = ps_woe && !ps_excm;
        old_rd = mreg[ph(ob, int'(rd_idx_a))];
        pc_ctr = pc_ctr + 32'd4;
        e.ev = 0; e.ek = 0; e.eo = 0; e.ep = pc_ctr; e.rv = 0; e.rp = 0; e.tag = tag;
        op_vld = 1; op_code = 3'(op); op_pc = pc_ctr; op_sidx = 4'(s); op_imm = 12'(imm);
        op_rot = 4'(rot); op_wgrp = 2'(w);
        case (op)
            1: begin
                if (s > 3 || !woe_ok) begin
                    e.ev = 1; e.ek = 7;
                end else begin
                    logic [31:0] v;
                    v = mreg[ph(ob, s)] - (32'(imm) << 3);
                    if (coll) begin
                        wr_en = 1; wr_idx = 4'((int'(ps_callinc) << 2) | s); wr_dat = 32'hDEAD_BEEF;
                    end
                    mreg[ph(ob, (int'(ps_callinc) << 2) | s)] = v;
                    mwb = (ob + int'(ps_callinc)) & 15;
                    mws[mwb] = 1'b1;
                end
            end
            2: begin
                a0 = mreg[ph(ob, 0)];
                n = int'(a0[31:30]);
                m = 0;
                for (int j = 3; j >= 1; j--) if (mws[(ob - j) & 15]) m = j;
                if (n == 0 || (m != 0 && m != n) || !woe_ok) begin
                    e.ev = 1; e.ek = 7;
                end else begin
                    nb = (ob - n) & 15;
                    if (mws[nb]) begin
                        mws[ob] = 1'b0;
                        e.rv = 1; e.rp = {pc_ctr[31:30], a0[29:0]};
                    end else begin
                        e.ev = 1; e.ek = 4'(3 + n); e.eo = 4'(ob);
                    end
                    mwb = nb;
                end
            end
            3: mwb = (ob + rot) & 15;
            4: begin
                if (woe_ok) begin
                    n = 0;
                    for (k = w; k >= 1; k--) if (mws[(ob + k) & 15]) n = k;
                    if (n != 0) begin
                        m = (ob + n) & 15;
                        e.ev = 1; e.eo = 4'(ob);
                        e.ek = mws[(m + 1) & 15] ? 4'd1 : (mws[(m + 2) & 15] ? 4'd2 : 4'd3);
                        mwb = m;
                    end
                end
            end
            5: begin
                if (!mws[(ob - 1) & 15] && !mws[(ob - 2) & 15] && !mws[(ob - 3) & 15]) begin
                    e.ev = 1; e.ek = 8;
                end
            end
            6: mwb = int'(ps_owb);
            default: ;
        endcase
        e.wb = 4'(mwb); e.ws = mws;
        exp_q.push_back(e);
        if (rdchk) begin
            #1;
            check(rd_dat_a == old_rd, {tag, " read during rotate"}, rd_dat_a, old_rd);
        end
        @(negedge clk);
        op_vld = 0; wr_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 reset state
        #1;
        check(wbase == 4'd0, "R2 base", 32'(wbase), 0);
        check(wstart == 16'h0001, "R2 mask", 32'(wstart), 1);
        check(!exc_vld && !ret_vld, "R2 flags", {exc_vld, ret_vld}, 0);
        @(negedge clk);
        rd_chk(5, "R2 file");

        // R1 mapping through the window
        for (int i = 0; i < 16; i++) wr(i, 32'h1000_0000 + 32'(i) * 32'h11);
        rd_chk(0, "R1"); rd_chk(7, "R1"); rd_chk(15, "R1");
        rd_idx_a = 4'd4;
        issue(3, 0, 0, -1, 0, 0, 1, "R1/R3 rotate -1");
        rd_chk(4, "R1 wrap"); rd_chk(0, "R1 wrap");
        issue(3, 0, 0, 1, 0, 0, 0, "R3 rotate +1");
        issue(3, 0, 0, 7, 0, 0, 0, "R3 rotate +7");
        issue(3, 0, 0, -8, 0, 0, 0, "R3 rotate -8");
        ps_owb = 4'd5; issue(6, 0, 0, 0, 0, 0, 0, "R4 restore 5");
        ps_owb = 4'd0; issue(6, 0, 0, 0, 0, 0, 0, "R4 restore 0");

        // R6 illegal entries
        ps_callinc = 2'd1;
        issue(1, 4, 1, 0, 0, 0, 0, "R6 s above 3");
        ps_woe = 0; issue(1, 1, 1, 0, 0, 0, 0, "R6 woe clear"); ps_woe = 1;
        ps_excm = 1; issue(1, 1, 1, 0, 0, 0, 0, "R6 excm set"); ps_excm = 0;
        rd_chk(5, "R6 file untouched");

        // R5 legal entries, one with a same-cycle write-port collision
        issue(1, 1, 2, 0, 0, 0, 0, "R5 entry");
        rd_chk(1, "R5 entry value");
        ps_callinc = 2'd2;
        issue(1, 3, 1, 0, 0, 1, 0, "R5 entry collision");
        rd_chk(3, "R5 entry wins");

        // R7 inactive and no-hit cases, R11 live caller
        ps_excm = 1; issue(4, 0, 0, 0, 3, 0, 0, "R7 inactive"); ps_excm = 0;
        issue(4, 0, 0, 0, 3, 0, 0, "R7 no hit");
        issue(5, 0, 0, 0, 0, 0, 0, "R11 caller live");

        do_reset();
        issue(5, 0, 0, 0, 0, 0, 0, "R11 alloca");
        issue(3, 0, 0, -2, 0, 0, 0, "R3");
        issue(4, 0, 0, 0, 1, 0, 0, "R7 short reach");
        issue(4, 0, 0, 0, 3, 0, 0, "R7/R12 overflow 12");

        do_reset();
        ps_callinc = 2'd2;
        issue(1, 0, 0, 0, 0, 0, 0, "R5");
        issue(3, 0, 0, -4, 0, 0, 0, "R3");
        issue(4, 0, 0, 0, 2, 0, 0, "R7 overflow 8");

        do_reset();
        ps_callinc = 2'd1;
        issue(1, 0, 0, 0, 0, 0, 0, "R5");
        issue(3, 0, 0, -3, 0, 0, 0, "R3");
        issue(4, 0, 0, 0, 2, 0, 0, "R7 overflow 4");

        // R8 / R9 returns
        do_reset();
        ps_callinc = 2'd1;
        issue(1, 2, 0, 0, 0, 0, 0, "R5");
        wr(0, 32'h4000_0123);
        issue(2, 0, 0, 0, 0, 0, 0, "R9 return");
        wr(0, 32'h0000_0000);
        issue(2, 0, 0, 0, 0, 0, 0, "R8 n zero");
        issue(1, 2, 0, 0, 0, 0, 0, "R5");
        wr(0, 32'h8000_0040);
        issue(2, 0, 0, 0, 0, 0, 0, "R8 n differs from m");
        wr(0, 32'h4000_0040);
        ps_woe = 0; issue(2, 0, 0, 0, 0, 0, 0, "R8 woe clear"); ps_woe = 1;

        // R10 underflows of each size
        do_reset();
        issue(3, 0, 0, 6, 0, 0, 0, "R3");
        wr(0, 32'hC000_0000);
        issue(2, 0, 0, 0, 0, 0, 0, "R10 underflow 12");
        issue(3, 0, 0, 3, 0, 0, 0, "R3");
        wr(0, 32'h4000_0000);
        issue(2, 0, 0, 0, 0, 0, 0, "R10 underflow 4");
        wr(0, 32'h8000_0000);
        issue(2, 0, 0, 0, 0, 0, 0, "R10/R12 underflow 8");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule